// File: doc/BRIEF.md
# Bus Undervoltage Restart Supervisor

This block watches two bus-voltage comparator flags on behalf of a lamp-ballast phase sequencer. During the bus check phase it gives the bus a bounded time to climb above the 95 % level. It either grants entry into soft start or reports a startup timeout. The phase sequencer supplies the phase code, and each of the four results comes back to it as a one-cycle request.

Once the sequencer is in run mode, the block watches the 75 % flag. A dip below that level counts only after it has lasted past a short debounce time. Once a dip is recognised, a long counter starts. If the bus recovers before the long limit, again judged through the same debounce, the block asks for a quick restart that resumes at ignition. If the dip outlasts the limit, the block asks for a full power-down and restart. All times are parameters in clock cycles. At 1 MHz the defaults give 80 ms, 84 µs and 800 ms. A sense level of 2.5 V stands for the rated bus voltage, so the 75 % comparator trips at 1.875 V.

Top module: `bus_uv_supervisor`

## Requirements
- R1: While `phase` equals 3 (bus check), `above_hi` sampled high within the first WIN_CYC clock edges of that stay raises `ss_grant` for exactly one cycle, starting the cycle after the sampling edge.
- R2: If `above_hi` stays low for the first WIN_CYC edges of a bus-check stay, `start_fault` pulses once, on the WIN_CYC-th edge of the stay. No grant follows in that stay, even if `above_hi` rises later.
- R3: If `above_hi` is first sampled high on the WIN_CYC-th edge of the stay, the block raises the grant and does not raise the timeout.
- R4: Outside `phase` equal to 8 (run), `below_lo` has no effect on any output.
- R5: In run mode, an undervoltage is recognised only after `below_lo` has been sampled high on DEB_CYC+1 consecutive edges. A shorter dip produces no output.
- R6: An undervoltage that stays recognised for LONG_CYC+1 edges produces one `full_restart` pulse.
- R7: When `below_lo` has been sampled low on DEB_CYC+1 consecutive edges during a recognised undervoltage that has not yet reached its limit, `quick_restart` pulses once. There is no quick restart after a full restart.
- R8: All four outputs are registered single-cycle pulses and are low during and right after reset (`rst_n` low, synchronous).
- R9: Leaving run mode abandons an undervoltage in progress without any pulse, and a later return to run starts clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase | input | 4 | Current sequencer phase code (3 = bus check, 8 = run) |
| above_hi | input | 1 | Bus above 95 % of rated |
| below_lo | input | 1 | Bus below 75 % of rated |
| ss_grant | output | 1 | Pulse: soft start may begin |
| start_fault | output | 1 | Pulse: bus did not reach 95 % in the window |
| full_restart | output | 1 | Pulse: request power-down and full restart |
| quick_restart | output | 1 | Pulse: request restart beginning at ignition |

## Verification
The grant and the timeout can fall due on the same edge, when `above_hi` first appears on the last counted cycle of the window. The bench raises it on exactly that cycle and expects a grant with no fault. It then opens a window with no rise at all and expects only the fault, followed by silence when `above_hi` comes late. Recovery and the long limit form a second boundary. The bench ends one dip exactly LONG_CYC cycles after it began and expects a quick restart, then ends another one cycle later and expects a full restart with no quick restart after it.

// File: rtl/bus_uv_pkg.sv
// Package: shared phase codes and state type for the bus undervoltage supervisor.
// Assumes the phase sequencer encodes phases as 4-bit numbers.
package bus_uv_pkg;
    localparam int PHASE_W = 4;
    localparam logic [PHASE_W-1:0] PH_BUS_CHECK = 4'd3;
    localparam logic [PHASE_W-1:0] PH_RUN       = 4'd8;

    typedef enum logic [0:0] {
        WIN_COUNTING = 1'b0,
        WIN_SETTLED  = 1'b1
    } win_state_t;
endpackage

// File: rtl/startup_window.sv
// Module: startup_window
// Counts the cycles of a bus-check stay. It grants soft start on the first high
// sample of the 95 % flag inside the window, or reports a timeout at the window end.
// Assumes: `active` stays high for the whole stay, and dropping it re-arms the window.
module startup_window #(
    parameter int WIN_CYC = 80_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic hi,
    output logic grant_o,
    output logic fault_o
);
    import bus_uv_pkg::*;

    localparam int CW = $clog2(WIN_CYC + 1);

    logic [CW-1:0] cnt;
    win_state_t    st;

    // Purpose: run the window and settle it on either a grant or a timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            st      <= WIN_COUNTING;
            grant_o <= 1'b0;
            fault_o <= 1'b0;
        end else begin
            grant_o <= 1'b0;
            fault_o <= 1'b0;
            if (!active) begin
                cnt <= '0;
                st  <= WIN_COUNTING;
            end else if (st == WIN_COUNTING) begin
                if (hi) begin
                    grant_o <= 1'b1;
                    st      <= WIN_SETTLED;
                end else if (cnt == CW'(WIN_CYC - 1)) begin
                    fault_o <= 1'b1;
                    st      <= WIN_SETTLED;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/level_debounce.sv
// Module: level_debounce
// Filters a raw flag. The filtered level follows the raw level only after they have
// disagreed on HOLD+1 consecutive edges. While disabled, the filter holds low.
// Assumes: HOLD >= 1.
module level_debounce #(
    parameter int HOLD = 84
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic raw,
    output logic filt
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] cnt;

    // Purpose: count consecutive disagreements and flip the filtered level at HOLD.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt  <= '0;
            filt <= 1'b0;
        end else if (raw != filt) begin
            if (cnt == CW'(HOLD)) begin
                filt <= raw;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            cnt <= '0;
        end
    end
endmodule

// File: rtl/uv_duration.sv
// Module: uv_duration
// Times a recognised undervoltage. It asks for a full restart once the condition
// has lasted LIMIT+1 edges. If the condition ends earlier, it asks for a quick restart.
// Assumes: `uv` is already debounced, and `en` low clears all history.
module uv_duration #(
    parameter int LIMIT = 800_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic uv,
    output logic full_o,
    output logic quick_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;
    logic          uv_q;
    logic          fired;

    // Purpose: count the undervoltage duration and classify its end.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt     <= '0;
            uv_q    <= 1'b0;
            fired   <= 1'b0;
            full_o  <= 1'b0;
            quick_o <= 1'b0;
        end else begin
            uv_q    <= uv;
            full_o  <= 1'b0;
            quick_o <= 1'b0;
            if (uv) begin
                if (!fired) begin
                    if (cnt == CW'(LIMIT)) begin
                        full_o <= 1'b1;
                        fired  <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end else begin
                cnt   <= '0;
                fired <= 1'b0;
                if (uv_q && !fired) begin
                    quick_o <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/bus_uv_supervisor.sv
// Module: bus_uv_supervisor (top)
// Supervises the startup bus check and undervoltage in run mode, and returns
// one-cycle requests to the phase sequencer.
// Assumes: comparator flags are already synchronous to clk, and phase changes are clean.
module bus_uv_supervisor #(
    parameter int WIN_CYC  = 80_000,
    parameter int DEB_CYC  = 84,
    parameter int LONG_CYC = 800_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] phase,
    input  logic       above_hi,
    input  logic       below_lo,
    output logic       ss_grant,
    output logic       start_fault,
    output logic       full_restart,
    output logic       quick_restart
);
    import bus_uv_pkg::*;

    logic in_check;
    logic in_run;
    logic uv_filt;

    // Purpose: decode the phases this block acts in.
    always_comb begin
        in_check = (phase == PH_BUS_CHECK);
        in_run   = (phase == PH_RUN);
    end

    startup_window #(.WIN_CYC(WIN_CYC)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (in_check),
        .hi      (above_hi),
        .grant_o (ss_grant),
        .fault_o (start_fault)
    );

    level_debounce #(.HOLD(DEB_CYC)) u_debounce (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (in_run),
        .raw   (below_lo),
        .filt  (uv_filt)
    );

    uv_duration #(.LIMIT(LONG_CYC)) u_duration (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (in_run),
        .uv      (uv_filt),
        .full_o  (full_restart),
        .quick_o (quick_restart)
    );
endmodule

// File: rtl/bus_uv_supervisor_chk.sv
// Module: bus_uv_supervisor_chk
// Port-level temporal checks on the supervisor, attached to it by a bind.
module bus_uv_supervisor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] phase,
    input logic       above_hi,
    input logic       below_lo,
    input logic       ss_grant,
    input logic       start_fault,
    input logic       full_restart,
    input logic       quick_restart
);
    import bus_uv_pkg::*;

    a_r1_grant_follows_hi: assert property (@(posedge clk) disable iff (!rst_n)
        ss_grant |-> ($past(above_hi) && $past(phase) == PH_BUS_CHECK));

    a_r2_fault_without_hi: assert property (@(posedge clk) disable iff (!rst_n)
        start_fault |-> (!$past(above_hi) && $past(phase) == PH_BUS_CHECK));

    a_r4_restart_only_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        (full_restart || quick_restart) |-> ($past(phase) == PH_RUN));

    a_r7_quick_after_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        quick_restart |-> !$past(below_lo));

    a_r8_grant_single: assert property (@(posedge clk) disable iff (!rst_n)
        ss_grant |=> !ss_grant);

    a_r8_fault_single: assert property (@(posedge clk) disable iff (!rst_n)
        start_fault |=> !start_fault);

    a_r8_full_single: assert property (@(posedge clk) disable iff (!rst_n)
        full_restart |=> !full_restart);

    a_r8_quick_single: assert property (@(posedge clk) disable iff (!rst_n)
        quick_restart |=> !quick_restart);
endmodule

bind bus_uv_supervisor bus_uv_supervisor_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .phase         (phase),
    .above_hi      (above_hi),
    .below_lo      (below_lo),
    .ss_grant      (ss_grant),
    .start_fault   (start_fault),
    .full_restart  (full_restart),
    .quick_restart (quick_restart)
);

// File: tb/bus_uv_supervisor_bench.sv
// Scoreboard bench: scenarios push expected pulses (kind, cycle), and a monitor pops and compares them.
module bus_uv_supervisor_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WIN  = 20;
    localparam int DEB  = 4;
    localparam int LONG = 30;

    localparam int K_GRANT = 0;
    localparam int K_FAULT = 1;
    localparam int K_FULL  = 2;
    localparam int K_QUICK = 3;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] phase;
    logic       above_hi;
    logic       below_lo;
    logic       ss_grant, start_fault, full_restart, quick_restart;

    int n_tests  = 0;
    int n_fail   = 0;
    int spurious = 0;
    int cyc      = 0;
    int exp_kind[$];
    int exp_at[$];

    bus_uv_supervisor #(.WIN_CYC(WIN), .DEB_CYC(DEB), .LONG_CYC(LONG)) u_bus_uv_supervisor (
        .clk           (clk),
        .rst_n         (rst_n),
        .phase         (phase),
        .above_hi      (above_hi),
        .below_lo      (below_lo),
        .ss_grant      (ss_grant),
        .start_fault   (start_fault),
        .full_restart  (full_restart),
        .quick_restart (quick_restart)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic string kname(input int k);
        case (k)
            K_GRANT: return "R1 ss_grant";
            K_FAULT: return "R2 start_fault";
            K_FULL:  return "R6 full_restart";
            default: return "R7 quick_restart";
        endcase
    endfunction

    task automatic go(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_at(input int kind, input int at);
        exp_kind.push_back(kind);
        exp_at.push_back(at);
    endtask

    task automatic quiet(input int n, input string tag);
        int s0 = spurious;
        go(n);
        n_tests++;
        if (spurious != s0) begin
            n_fail++;
            $display("FAIL %s: actual %0d unexpected pulses, expected 0", tag, spurious - s0);
        end
    endtask

    // Monitor: compare every output pulse against the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            for (int k = 0; k < 4; k++) begin
                logic p;
                int ek;
                int ea;
                p = (k == K_GRANT) ? ss_grant : (k == K_FAULT) ? start_fault :
                    (k == K_FULL) ? full_restart : quick_restart;
                if (p) begin
                    n_tests++;
                    if (exp_kind.size() == 0) begin
                        n_fail++;
                        spurious++;
                        $display("FAIL R8 unexpected pulse: actual %s at cycle %0d, expected none",
                                 kname(k), cyc);
                    end else begin
                        ek = exp_kind.pop_front();
                        ea = exp_at.pop_front();
                        if (ek != k || ea != cyc) begin
                            n_fail++;
                            $display("FAIL %s: actual %s at cycle %0d, expected at cycle %0d",
                                     kname(ek), kname(k), cyc, ea);
                        end
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R8 watchdog: actual run still active, expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        phase    = 4'd0;
        above_hi = 1'b0;
        below_lo = 1'b0;
        go(4);
        rst_n = 1'b1;
        go(1);
        // R8: reset state
        n_tests++;
        if ({ss_grant, start_fault, full_restart, quick_restart} != 4'b0) begin
            n_fail++;
            $display("FAIL R8 reset: actual %b, expected 0000",
                     {ss_grant, start_fault, full_restart, quick_restart});
        end

        // R1: early rise inside the window
        phase = 4'd3;
        go(5);
        above_hi = 1'b1;
        expect_at(K_GRANT, cyc + 1);
        go(3);
        above_hi = 1'b0;
        phase = 4'd0;
        go(2);

        // R3: rise on the last window cycle -> grant, no fault
        phase = 4'd3;
        go(WIN - 1);
        above_hi = 1'b1;
        expect_at(K_GRANT, cyc + 1);
        go(3);
        above_hi = 1'b0;
        phase = 4'd0;
        go(2);

        // R2: no rise -> timeout, a late rise is then ignored
        phase = 4'd3;
        expect_at(K_FAULT, cyc + WIN);
        go(WIN + 2);
        above_hi = 1'b1;
        quiet(6, "R2 late rise after timeout");
        above_hi = 1'b0;
        phase = 4'd0;
        go(2);

        // R4: undervoltage outside run is ignored
        phase = 4'd5;
        below_lo = 1'b1;
        quiet(3 * DEB + LONG, "R4 low flag outside run");
        below_lo = 1'b0;

        // R5: dip of DEB samples is filtered
        phase = 4'd8;
        go(2);
        below_lo = 1'b1;
        go(DEB);
        below_lo = 1'b0;
        quiet(3 * DEB, "R5 short dip");

        // R7: recovery soon after recognition -> quick restart
        below_lo = 1'b1;
        go(DEB + 3);
        below_lo = 1'b0;
        expect_at(K_QUICK, cyc + DEB + 2);
        go(2 * DEB + 4);

        // R7: recovery on the last allowed cycle -> quick restart
        below_lo = 1'b1;
        go(LONG);
        below_lo = 1'b0;
        expect_at(K_QUICK, cyc + DEB + 2);
        go(2 * DEB + 4);

        // R6: one cycle longer -> full restart, then no quick restart (R7)
        below_lo = 1'b1;
        expect_at(K_FULL, cyc + DEB + LONG + 2);
        go(LONG + 1);
        below_lo = 1'b0;
        quiet(2 * DEB + 6, "R7 no quick after full");

        // R9: leaving run mid-undervoltage discards it
        below_lo = 1'b1;
        go(DEB + 5);
        phase = 4'd0;
        below_lo = 1'b0;
        quiet(LONG + 10, "R9 left run");
        phase = 4'd8;
        quiet(DEB + 4, "R9 clean return to run");
        phase = 4'd0;
        go(5);

        // Scoreboard must be drained
        n_tests++;
        if (exp_kind.size() != 0) begin
            n_fail++;
            $display("FAIL %s missing: actual %0d pending, expected 0",
                     kname(exp_kind[0]), exp_kind.size());
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule